// File: doc/BRIEF.md
# Transposition Table Replacement Controller

This block looks up and conditionally updates one slot of a transposition table. An iterative-deepening proof-number search uses the table so that it does not expand the same node twice. The search side presents a table index together with a compressed code of the current position, its evaluation and its mate depth. The controller reads the slot at that index from a synchronous single-port memory. It compares the stored position code with the presented one, so that a slot holding a different position is never mistaken for a hit.

The lookup is classified as empty, hit or collision. On a hit, the stored evaluation and depth are handed back. The controller then decides whether to write the slot. An unoccupied slot is always claimed. A colliding slot is replaced only when the incoming evaluation is strictly smaller than the stored one and the stored slot does not record a found mate. A slot with a nonzero depth field counts as a found mate and is never evicted.

The sequence is accept, read, compare, respond. While it runs, the controller shows busy and refuses new requests. Generating the hash index and running the search are left to neighbouring blocks.

Top module: `tt_replace_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, rsp_valid, mem_en and mem_we are all low.
- R2: A request is taken when req_valid is high and busy is low at a clock edge. busy is high from the next cycle up to and including the response cycle. A req_valid seen while busy is high is ignored: it yields no response and no memory access.
- R3: In the first cycle after a request is taken, mem_en is 1, mem_we is 0 and mem_addr equals the request index.
- R4: rsp_valid is high for exactly one cycle, the third cycle after the request edge, which is one cycle after read data arrives. busy is low in the cycle after the response.
- R5: Memory word layout, from least significant bit up: bits [POS_W-1:0] hold the position code, the next DEPTH_W bits hold the mate depth, the next EVAL_W bits hold the evaluation, and the top bit is the occupancy flag.
- R6: If the stored occupancy flag is 0, rsp_kind is 0 (empty). The slot is then written with the flag set and the request's evaluation, depth and position.
- R7: If the slot is occupied and the stored code equals the request code, rsp_kind is 1 (hit). rsp_eval and rsp_depth carry the stored fields, and nothing is written.
- R8: If the slot is occupied and the codes differ, rsp_kind is 2 (collision). On every non-hit response, rsp_eval and rsp_depth are zero.
- R9: On a collision whose stored depth is zero, the slot is overwritten with the request data when the request evaluation is strictly smaller than the stored evaluation.
- R10: On a collision whose stored depth is nonzero (a found mate), the slot is never written, whatever the evaluation.
- R11: On a collision with an evaluation equal to or larger than the stored one, nothing is written.
- R12: Any table write happens only in the response cycle, with mem_en and mem_we both 1 and mem_addr equal to the request index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_index | input | IDX_W | Table slot to look up |
| req_pos | input | POS_W | Compressed code of the current position |
| req_eval | input | EVAL_W | Evaluation of the current position |
| req_depth | input | DEPTH_W | Mate depth (nonzero when a mate was found) |
| busy | output | 1 | Sequence in progress, requests refused |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 0 empty, 1 hit, 2 collision |
| rsp_eval | output | EVAL_W | Stored evaluation on a hit, else zero |
| rsp_depth | output | DEPTH_W | Stored depth on a hit, else zero |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IDX_W | Memory address |
| mem_wdata | output | ENTRY_W | Memory write word |
| mem_rdata | input | ENTRY_W | Memory read word, valid the cycle after a read |

## Verification
The bound checker watches the handshake and timing on every cycle. It checks that busy rises after acceptance, that the read cycle drives no write, that the response is a single-cycle pulse followed by idle, and that writes occur only in the response cycle. It also checks the policy outcomes that can be read from the ports in one cycle: empty slots are written with the flag set, hits never write, and found-mate slots are never written. Whether the right slot ends up holding the right data across a sequence of requests can only be shown by the bench. This includes strict versus equal evaluations, replacement after replacement, and requests dropped while busy. The bench compares its own table model against the memory after each scenario.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        KIND_EMPTY = 2'd0,
        KIND_HIT   = 2'd1,
        KIND_COLL  = 2'd2
    } tt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CMP  = 2'd2,
        ST_FIN  = 2'd3
    } tt_state_e;

endpackage

// File: rtl/tt_pos_match.sv
// Chunked equality of two position codes; chunks are ANDed together.
module tt_pos_match #(
    parameter int POS_W   = 88,
    parameter int CHUNK_W = 16
) (
    input  logic [POS_W-1:0] code_a,
    input  logic [POS_W-1:0] code_b,
    output logic             equal
);
    localparam int NCHUNK = (POS_W + CHUNK_W - 1) / CHUNK_W;

    logic [NCHUNK-1:0] chunk_eq;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int LO = i * CHUNK_W;
        localparam int HI = ((i + 1) * CHUNK_W > POS_W) ? POS_W - 1 : (i + 1) * CHUNK_W - 1;
        assign chunk_eq[i] = (code_a[HI:LO] == code_b[HI:LO]);
    end

    assign equal = &chunk_eq;
endmodule

// File: rtl/tt_policy.sv
// Classifies a lookup and decides whether the slot is written.
module tt_policy
    import tt_pkg::*;
#(
    parameter int EVAL_W  = 8,
    parameter int DEPTH_W = 11
) (
    input  logic               slot_used,
    input  logic               code_equal,
    input  logic [EVAL_W-1:0]  slot_eval,
    input  logic [DEPTH_W-1:0] slot_depth,
    input  logic [EVAL_W-1:0]  new_eval,
    output tt_kind_e           kind,
    output logic               do_write
);
    logic mate_locked;
    logic better;

    always_comb begin
        mate_locked = (slot_depth != '0);
        better      = (new_eval < slot_eval);
        if (!slot_used) begin
            kind     = KIND_EMPTY;
            do_write = 1'b1;
        end else if (code_equal) begin
            kind     = KIND_HIT;
            do_write = 1'b0;
        end else begin
            kind     = KIND_COLL;
            do_write = better && !mate_locked;
        end
    end
endmodule

// File: rtl/tt_replace_ctrl.sv
module tt_replace_ctrl
    import tt_pkg::*;
#(
    parameter int IDX_W   = 20,
    parameter int EVAL_W  = 8,
    parameter int DEPTH_W = 11,
    parameter int POS_W   = 88,
    parameter int CHUNK_W = 16,
    localparam int ENTRY_W = 1 + EVAL_W + DEPTH_W + POS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [POS_W-1:0]   req_pos,
    input  logic [EVAL_W-1:0]  req_eval,
    input  logic [DEPTH_W-1:0] req_depth,
    output logic               busy,
    output logic               rsp_valid,
    output logic [1:0]         rsp_kind,
    output logic [EVAL_W-1:0]  rsp_eval,
    output logic [DEPTH_W-1:0] rsp_depth,
    output logic               mem_en,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic [ENTRY_W-1:0] mem_rdata
);
    localparam int DEPTH_LO = POS_W;
    localparam int EVAL_LO  = POS_W + DEPTH_W;
    localparam int FLAG_BIT = ENTRY_W - 1;

    typedef struct packed {
        tt_state_e          st;
        logic [IDX_W-1:0]   idx;
        logic [POS_W-1:0]   pos;
        logic [EVAL_W-1:0]  eval;
        logic [DEPTH_W-1:0] depth;
        tt_kind_e           kind;
        logic [EVAL_W-1:0]  out_eval;
        logic [DEPTH_W-1:0] out_depth;
        logic               wr;
    } regs_t;

    regs_t r_d, r_q;

    // fields of the word returned by the memory
    logic               slot_used;
    logic [EVAL_W-1:0]  slot_eval;
    logic [DEPTH_W-1:0] slot_depth;
    logic [POS_W-1:0]   slot_pos;
    logic               code_equal;
    tt_kind_e           kind_w;
    logic               write_w;

    assign slot_used  = mem_rdata[FLAG_BIT];
    assign slot_eval  = mem_rdata[EVAL_LO +: EVAL_W];
    assign slot_depth = mem_rdata[DEPTH_LO +: DEPTH_W];
    assign slot_pos   = mem_rdata[POS_W-1:0];

    tt_pos_match #(
        .POS_W   (POS_W),
        .CHUNK_W (CHUNK_W)
    ) i_match (
        .code_a (slot_pos),
        .code_b (r_q.pos),
        .equal  (code_equal)
    );

    tt_policy #(
        .EVAL_W  (EVAL_W),
        .DEPTH_W (DEPTH_W)
    ) i_policy (
        .slot_used  (slot_used),
        .code_equal (code_equal),
        .slot_eval  (slot_eval),
        .slot_depth (slot_depth),
        .new_eval   (r_q.eval),
        .kind       (kind_w),
        .do_write   (write_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_READ;
                    r_d.idx   = req_index;
                    r_d.pos   = req_pos;
                    r_d.eval  = req_eval;
                    r_d.depth = req_depth;
                end
            end
            ST_READ: r_d.st = ST_CMP;
            ST_CMP: begin
                r_d.st        = ST_FIN;
                r_d.kind      = kind_w;
                r_d.wr        = write_w;
                r_d.out_eval  = (kind_w == KIND_HIT) ? slot_eval : '0;
                r_d.out_depth = (kind_w == KIND_HIT) ? slot_depth : '0;
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
                r_d.wr = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign rsp_valid = (r_q.st == ST_FIN);
    assign rsp_kind  = r_q.kind;
    assign rsp_eval  = r_q.out_eval;
    assign rsp_depth = r_q.out_depth;
    assign mem_we    = (r_q.st == ST_FIN) && r_q.wr;
    assign mem_en    = (r_q.st == ST_READ) || mem_we;
    assign mem_addr  = r_q.idx;
    assign mem_wdata = {1'b1, r_q.eval, r_q.depth, r_q.pos};
endmodule

// File: rtl/tt_replace_ctrl_chk.sv
module tt_replace_ctrl_chk #(
    parameter int IDX_W   = 20,
    parameter int EVAL_W  = 8,
    parameter int DEPTH_W = 11,
    parameter int POS_W   = 88,
    localparam int ENTRY_W = 1 + EVAL_W + DEPTH_W + POS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               rsp_valid,
    input logic [1:0]         rsp_kind,
    input logic               mem_en,
    input logic               mem_we,
    input logic [ENTRY_W-1:0] mem_wdata,
    input logic [ENTRY_W-1:0] mem_rdata
);
    localparam int DEPTH_LO = POS_W;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R3
    read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_en && !mem_we));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R12
    write_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rsp_valid && mem_en));

    // R6
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd0) |-> (mem_we && mem_wdata[ENTRY_W-1]));

    // R7
    hit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd1) |-> !mem_we);

    // R10
    mate_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(mem_rdata[ENTRY_W-1])
         && ($past(mem_rdata[DEPTH_LO +: DEPTH_W]) != '0)) |-> !mem_we);
endmodule

bind tt_replace_ctrl tt_replace_ctrl_chk #(
    .IDX_W   (IDX_W),
    .EVAL_W  (EVAL_W),
    .DEPTH_W (DEPTH_W),
    .POS_W   (POS_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/test_tt_replace_ctrl.sv
module test_tt_replace_ctrl;
    localparam int IDX_W   = 6;
    localparam int EVAL_W  = 8;
    localparam int DEPTH_W = 11;
    localparam int POS_W   = 88;
    localparam int ENTRY_W = 1 + EVAL_W + DEPTH_W + POS_W;
    localparam int SLOTS   = 1 << IDX_W;

    typedef struct {
        logic [1:0]         kind;
        logic [EVAL_W-1:0]  eval;
        logic [DEPTH_W-1:0] depth;
        logic               we;
        logic [ENTRY_W-1:0] wdata;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [IDX_W-1:0]   req_index = '0;
    logic [POS_W-1:0]   req_pos = '0;
    logic [EVAL_W-1:0]  req_eval = '0;
    logic [DEPTH_W-1:0] req_depth = '0;
    logic               busy, rsp_valid, mem_en, mem_we;
    logic [1:0]         rsp_kind;
    logic [EVAL_W-1:0]  rsp_eval;
    logic [DEPTH_W-1:0] rsp_depth;
    logic [IDX_W-1:0]   mem_addr;
    logic [ENTRY_W-1:0] mem_wdata;
    logic [ENTRY_W-1:0] mem_rdata = '0;

    logic [ENTRY_W-1:0] mem     [SLOTS];
    logic [ENTRY_W-1:0] exp_mem [SLOTS];
    exp_t               sb_q[$];
    int                 total = 0;
    int                 fails = 0;
    bit                 done = 1'b0;

    always #4 clk = ~clk;

    tt_replace_ctrl #(
        .IDX_W (IDX_W), .EVAL_W (EVAL_W), .DEPTH_W (DEPTH_W), .POS_W (POS_W)
    ) i_tt_replace_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_index (req_index),
        .req_pos (req_pos), .req_eval (req_eval), .req_depth (req_depth),
        .busy (busy), .rsp_valid (rsp_valid), .rsp_kind (rsp_kind),
        .rsp_eval (rsp_eval), .rsp_depth (rsp_depth), .mem_en (mem_en),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // single-port synchronous memory model
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", 128'(rsp_kind), 128'hF);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_kind == e.kind, "R6/R7/R8 kind", 128'(rsp_kind), 128'(e.kind));
                chk(rsp_eval == e.eval && rsp_depth == e.depth, "R7/R8 eval,depth",
                    {rsp_eval, rsp_depth}, {e.eval, e.depth});
                chk(mem_we == e.we, "R9/R10/R11 write decision", 128'(mem_we), 128'(e.we));
                if (e.we)
                    chk(mem_wdata == e.wdata && mem_en, "R5/R12 write word",
                        128'(mem_wdata), 128'(e.wdata));
            end
        end
    end

    // driver: computes expected outcome, pushes it, runs one request
    task automatic lookup(input logic [IDX_W-1:0] idx, input logic [POS_W-1:0] pos,
                          input logic [EVAL_W-1:0] ev, input logic [DEPTH_W-1:0] dp,
                          input bit junk);
        exp_t               e;
        logic [ENTRY_W-1:0] s;
        logic [ENTRY_W-1:0] nw;
        s  = exp_mem[idx];
        nw = {1'b1, ev, dp, pos};
        e.eval = '0; e.depth = '0; e.we = 1'b0; e.wdata = nw;
        if (!s[ENTRY_W-1]) begin
            e.kind = 2'd0; e.we = 1'b1;
        end else if (s[POS_W-1:0] == pos) begin
            e.kind  = 2'd1;
            e.eval  = s[POS_W+DEPTH_W +: EVAL_W];
            e.depth = s[POS_W +: DEPTH_W];
        end else begin
            e.kind = 2'd2;
            e.we   = (ev < s[POS_W+DEPTH_W +: EVAL_W]) && (s[POS_W +: DEPTH_W] == '0);
        end
        if (e.we) exp_mem[idx] = nw;
        sb_q.push_back(e);
        while (busy) @(negedge clk);
        req_index = idx; req_pos = pos; req_eval = ev; req_depth = dp; req_valid = 1'b1;
        @(negedge clk);
        // R3 read cycle
        chk(busy && mem_en && !mem_we && mem_addr == idx, "R3 read cycle",
            {busy, mem_en, mem_we, 64'(mem_addr)}, {3'b110, 64'(idx)});
        if (junk) begin
            req_valid = 1'b1; req_index = idx ^ 6'h3F; req_eval = '0; req_pos = ~pos;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        chk(!rsp_valid && busy, "R4 no early response", 128'(rsp_valid), 128'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && busy, "R4 response cycle", {rsp_valid, busy}, 2'b11);
        @(negedge clk);
        chk(!rsp_valid && !busy, "R4 idle after response", {rsp_valid, busy}, 2'b00);
    endtask

    task automatic compare_table(input string tag);
        for (int i = 0; i < SLOTS; i++)
            chk(mem[i] === exp_mem[i], tag, 128'(mem[i]), 128'(exp_mem[i]));
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            mem[i] = '0; exp_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !mem_en && !mem_we, "R1 in reset",
            {busy, rsp_valid, mem_en, mem_we}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !mem_en && !mem_we, "R1 after reset",
            {busy, rsp_valid, mem_en, mem_we}, 4'b0);

        lookup(6'd5, 88'hA1, 8'd50, 11'd0, 1'b0);   // R6 empty claim
        lookup(6'd5, 88'hA1, 8'd99, 11'd0, 1'b0);   // R7 hit returns stored
        lookup(6'd5, 88'hB2, 8'd60, 11'd0, 1'b0);   // R11 larger eval kept
        lookup(6'd5, 88'hB2, 8'd50, 11'd0, 1'b0);   // R11 equal eval kept
        lookup(6'd5, 88'hB2, 8'd20, 11'd0, 1'b0);   // R9 strict smaller replaces
        lookup(6'd5, 88'hB2, 8'd77, 11'd0, 1'b0);   // R7 hit on new code
        lookup(6'd9, {8'hFF, 80'h1234}, 8'd100, 11'd7, 1'b0); // R6 mate entry
        lookup(6'd9, 88'h1, 8'd1, 11'd0, 1'b0);     // R10 mate protected
        lookup(6'd9, {8'hFF, 80'h1234}, 8'd3, 11'd0, 1'b0); // R7 depth returned
        lookup(6'd5, 88'hC3, 8'd200, 11'd0, 1'b1);  // R2 junk while busy ignored
        compare_table("R2/R9/R10 table contents");

        begin
            logic [31:0] s;
            s = 32'h1357_9BDF;
            for (int n = 0; n < 40; n++) begin
                s = s * 32'd1103515245 + 32'd12345;
                lookup(IDX_W'(s[10:8]), 88'(s[17:16]), s[31:24],
                       (s[5:4] == 2'd0) ? 11'(s[14:12]) : 11'd0, s[20]);
            end
        end
        compare_table("R9/R10/R11 table after sweep");
        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R2 all responses seen", 128'(sb_q.size()), 128'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule